// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block timestamps transitions on one external input against a free-running 16-bit base timer. The input first crosses into the timer clock domain through a two-stage synchronizer. A noise filter can sit after the synchronizer. It samples only when a sampling strobe is high, and it changes its output only after three equal samples in a row. When the selected transition (rising only, or both directions) reaches the edge detector, the current timer count is copied into the capture register and a sticky request flag is set.

Software clears the flag by writing zero to it. Each of the two interrupt request outputs pulses for one cycle, and only when the flag goes from clear to set. A capture that arrives while the flag is still set refreshes the captured count but raises no interrupt. This lets software that is slow to service the flag read the most recent timestamp without seeing a flood of requests.

Top module: `cap_channel`

## Requirements
- R1: During reset and after it is released, `cap_val` is 0, `req_flag` is 0, and both `irq0` and `irq1` are 0.
- R2: With `trig_sel` = 2'b01, a low-to-high transition of the edge-detector input causes a capture. A high-to-low transition does not.
- R3: With `trig_sel` = 2'b11, transitions in both directions cause a capture.
- R4: With `trig_sel` = 2'b00 or 2'b10, no transition causes a capture, and the flag and interrupts are left unchanged.
- R5: With `filt_ctl[1]` = 1, the filter is enabled. A synchronized level that lasts fewer than three consecutive strobed samples does not change the filtered signal and causes no capture. With `filt_ctl[1]` = 0, the synchronized pin drives the edge detector directly.
- R6: Without the filter, suppose the pin changes before the clock edge at which the timer reads T. The capture register then holds T+2 (modulo 2^16) after the capture.
- R7: With the filter enabled and `smp_en` held high, suppose the pin changes before the clock edge at which the timer reads T. The capture register then holds T+5.
- R8: On each capture, `cap_val` loads the base timer count and `req_flag` becomes 1. Without a capture, `cap_val` holds its value.
- R9: `irq0` and `irq1` are both high for exactly one cycle, in the same cycle in which `req_flag` first reads 1 after being 0. A capture while `req_flag` is already 1 updates `cap_val` but pulses neither output.
- R10: A cycle with `flag_wr` = 1 and `flag_wdata` = 0 clears `req_flag`. A write of 1 leaves it unchanged.
- R11: If a clear write and a capture fall in the same cycle, `req_flag` stays 1.
- R12: The base timer counts up by one per clock from 0 after reset and wraps from 16'hFFFF to 16'h0000. A capture near the wrap point holds the wrapped value.
- R13: While `smp_en` is 0, the filter takes no samples, so a pin change produces no capture in filtered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base timer clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sampling strobe for the noise filter |
| pin_in | input | 1 | Asynchronous external input |
| trig_sel | input | 2 | Edge selection: 01 rising, 11 both, others none |
| filt_ctl | input | 2 | Filter control; filter active when bit 1 is set |
| flag_wr | input | 1 | Write strobe for the request flag |
| flag_wdata | input | 1 | Value written to the flag (only 0 has effect) |
| cap_val | output | 16 | Captured base timer count |
| req_flag | output | 1 | Sticky capture request flag |
| irq0 | output | 1 | First interrupt request pulse |
| irq1 | output | 1 | Second interrupt request pulse |

## Verification
A software clear of the request flag and a new capture can land on the same clock edge. The bench provokes this by driving an unfiltered rising pin edge, then raising the zero write exactly two cycles later, which is the cycle in which the captured count lands. The flag must stay set and neither interrupt may pulse. A capture into an already-set flag is also provoked; there the count must move while the interrupt outputs stay low.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int unsigned TMR_W = 16;

    typedef enum logic [1:0] {
        TRG_OFF  = 2'b00,
        TRG_RISE = 2'b01,
        TRG_RSVD = 2'b10,
        TRG_BOTH = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        trig_sel_e sel;
        logic      filt_on;
    } cap_cfg_t;

    function automatic logic filter_enabled(input logic [1:0] ctl);
        return ctl[1];
    endfunction

    function automatic logic edge_fires(input trig_sel_e sel, input edge_t e);
        unique case (sel)
            TRG_RISE: return e.rise;
            TRG_BOTH: return e.rise | e.fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
    parameter int unsigned TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp,
    input  logic d,
    output logic q
);
    localparam int unsigned HW = TAPS - 1;

    logic [HW-1:0]   hist;
    logic [TAPS-1:0] window;
    logic            all_hi;
    logic            all_lo;

    assign window = {hist, d};
    assign all_hi = &window;
    assign all_lo = ~|window;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            q    <= 1'b0;
        end else if (smp) begin
            hist <= window[HW-1:0];
            if (all_hi)      q <= 1'b1;
            else if (all_lo) q <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src,
    output edge_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= src;
    end

    assign ev.rise = src & ~prev;
    assign ev.fall = ~src & prev;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int unsigned TW        = TMR_W,
    parameter int unsigned SYNC_LEN  = 2,
    parameter int unsigned FILT_TAPS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_en,
    input  logic          pin_in,
    input  logic [1:0]    trig_sel,
    input  logic [1:0]    filt_ctl,
    input  logic          flag_wr,
    input  logic          flag_wdata,
    output logic [TW-1:0] cap_val,
    output logic          req_flag,
    output logic          irq0,
    output logic          irq1
);
    cap_cfg_t      cfg;
    logic [TW-1:0] base_tmr;
    logic          pin_s;
    logic          pin_f;
    logic          det_src;
    edge_t         ev;
    logic          trig;
    logic          clr_req;

    assign cfg.sel     = trig_sel_e'(trig_sel);
    assign cfg.filt_on = filter_enabled(filt_ctl);

    always_ff @(posedge clk) begin
        if (rst) base_tmr <= '0;
        else     base_tmr <= base_tmr + 1'b1;
    end

    cap_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    cap_filter #(.TAPS(FILT_TAPS)) u_filt (
        .clk (clk),
        .rst (rst),
        .smp (smp_en),
        .d   (pin_s),
        .q   (pin_f)
    );

    assign det_src = cfg.filt_on ? pin_f : pin_s;

    cap_edge u_edge (
        .clk (clk),
        .rst (rst),
        .src (det_src),
        .ev  (ev)
    );

    assign trig    = edge_fires(cfg.sel, ev);
    assign clr_req = flag_wr & ~flag_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val  <= '0;
            req_flag <= 1'b0;
            irq0     <= 1'b0;
            irq1     <= 1'b0;
        end else begin
            irq0 <= trig & ~req_flag;
            irq1 <= trig & ~req_flag;
            if (trig) begin
                cap_val  <= base_tmr;
                req_flag <= 1'b1;
            end else if (clr_req) begin
                req_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
    parameter int unsigned TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    trig_sel,
    input logic          flag_wr,
    input logic          flag_wdata,
    input logic          trig,
    input logic [TW-1:0] cap_val,
    input logic          req_flag,
    input logic          irq0,
    input logic          irq1
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq0 |=> !irq0); // R9
    AST_IRQ_ON_SET: assert property (@(posedge clk) disable iff (rst)
        (irq0 || irq1) |-> (req_flag && !$past(req_flag))); // R9
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(cap_val)); // R8
    AST_TRIG_SETS: assert property (@(posedge clk) disable iff (rst)
        trig |=> req_flag); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (req_flag && !(flag_wr && !flag_wdata)) |=> req_flag); // R10
    AST_SEL_OFF: assert property (@(posedge clk) disable iff (rst)
        (trig_sel == 2'b00 || trig_sel == 2'b10) |-> !trig); // R4
endmodule

bind cap_channel cap_channel_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_sel   (trig_sel),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .trig       (trig),
    .cap_val    (cap_val),
    .req_flag   (req_flag),
    .irq0       (irq0),
    .irq1       (irq1)
);

// File: tb/tb_cap_channel.sv
module tb_cap_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b1;
    logic        pin_in = 1'b0;
    logic [1:0]  trig_sel = 2'b01;
    logic [1:0]  filt_ctl = 2'b00;
    logic        flag_wr = 1'b0;
    logic        flag_wdata = 1'b0;
    logic [15:0] cap_val;
    logic        req_flag;
    logic        irq0;
    logic        irq1;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    logic [15:0] m_tmr, m_cap;
    logic m_flag, m_irq, m_s1, m_s2, m_h0, m_h1, m_fo, m_prev;

    always #5 clk = ~clk;

    cap_channel dut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .pin_in(pin_in),
        .trig_sel(trig_sel), .filt_ctl(filt_ctl), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .cap_val(cap_val), .req_flag(req_flag),
        .irq0(irq0), .irq1(irq1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic src, rise, fall, trg;
        if (rst) begin
            m_tmr = '0; m_cap = '0; m_flag = 0; m_irq = 0;
            m_s1 = 0; m_s2 = 0; m_h0 = 0; m_h1 = 0; m_fo = 0; m_prev = 0;
        end else begin
            src  = filt_ctl[1] ? m_fo : m_s2;
            rise = src && !m_prev;
            fall = !src && m_prev;
            trg  = (trig_sel == 2'b01 && rise) || (trig_sel == 2'b11 && (rise || fall));
            m_irq = trg && !m_flag;
            if (trg) begin
                m_cap  = m_tmr;
                m_flag = 1'b1;
            end else if (flag_wr && !flag_wdata) begin
                m_flag = 1'b0;
            end
            m_prev = src;
            if (smp_en) begin
                if (m_h1 && m_h0 && m_s2) m_fo = 1'b1;
                else if (!m_h1 && !m_h0 && !m_s2) m_fo = 1'b0;
                m_h1 = m_h0;
                m_h0 = m_s2;
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
            m_tmr = m_tmr + 16'd1;
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R8 cap_val model", cap_val, m_cap);
        chk("R8 req_flag model", req_flag, m_flag);
        chk("R9 irq0 model", irq0, m_irq);
        chk("R9 irq1 model", irq1, m_irq);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_flag();
        flag_wr = 1'b1; flag_wdata = 1'b0;
        step();
        flag_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] t0, c0;
        int irqs;
        @(negedge clk);
        run(3);
        chk("R1 cap after reset", cap_val, 0);
        chk("R1 flag after reset", req_flag, 0);
        chk("R1 irq after reset", irq0 | irq1, 0);
        rst = 1'b0;
        run(5);
        chk("R1 idle flag", req_flag, 0);

        // R6, R2, R9: unfiltered rising capture
        t0 = m_tmr; pin_in = 1'b1;
        step(); step();
        chk("R6 no capture yet", req_flag, 0);
        step();
        chk("R6 cap = T+2", cap_val, int'(t0 + 16'd2));
        chk("R9 irq0 pulse", irq0, 1);
        chk("R9 irq1 pulse", irq1, 1);
        step();
        chk("R9 irq single cycle", irq0 | irq1, 0);
        c0 = cap_val;
        pin_in = 1'b0; run(6);
        chk("R2 falling ignored", cap_val, int'(c0));

        // R9: capture into set flag
        irqs = 0;
        pin_in = 1'b1;
        for (int i = 0; i < 6; i++) begin step(); irqs += irq0 + irq1; end
        chk("R9 cap refreshed", cap_val != c0, 1);
        chk("R9 no irq while flag set", irqs, 0);

        // R10: write one no effect, write zero clears
        flag_wr = 1'b1; flag_wdata = 1'b1; step(); flag_wr = 1'b0;
        chk("R10 write one ignored", req_flag, 1);
        clear_flag();
        chk("R10 write zero clears", req_flag, 0);

        // R3: both edges
        trig_sel = 2'b11;
        t0 = m_tmr; pin_in = 1'b0; run(3);
        chk("R3 falling capture", cap_val, int'(t0 + 16'd2));
        chk("R3 flag set", req_flag, 1);
        clear_flag();

        // R4: disabled selections
        for (int s = 0; s < 3; s += 2) begin
            trig_sel = 2'(s);
            c0 = cap_val;
            pin_in = ~pin_in; run(5);
            pin_in = ~pin_in; run(5);
            chk("R4 no capture", cap_val, int'(c0));
            chk("R4 flag clear", req_flag, 0);
        end

        // R5: filter rejects a two-cycle pulse
        trig_sel = 2'b01; filt_ctl = 2'b10; pin_in = 1'b0; run(8);
        c0 = cap_val;
        pin_in = 1'b1; run(2); pin_in = 1'b0; run(10);
        chk("R5 short pulse dropped", req_flag, 0);
        chk("R5 cap kept", cap_val, int'(c0));

        // R7: filtered latency
        t0 = m_tmr; pin_in = 1'b1; run(6);
        chk("R7 cap = T+5", cap_val, int'(t0 + 16'd5));
        clear_flag();
        pin_in = 1'b0; run(8);

        // R13: no strobes, no filtered change
        smp_en = 1'b0; pin_in = 1'b1; run(12);
        chk("R13 held without strobe", req_flag, 0);
        smp_en = 1'b1; run(8);
        chk("R13 resumes with strobe", req_flag, 1);

        // R11: clear and capture on the same edge, flag already set
        filt_ctl = 2'b00; pin_in = 1'b0; run(6);
        pin_in = 1'b1; step(); step();
        flag_wr = 1'b1; flag_wdata = 1'b0; step(); flag_wr = 1'b0;
        chk("R11 trigger wins", req_flag, 1);
        chk("R11 no irq", irq0 | irq1, 0);
        clear_flag();
        pin_in = 1'b0; run(4);

        // R12: wrap of the base timer
        while (m_tmr != 16'hFFFE) step();
        pin_in = 1'b1; run(3);
        chk("R12 wrapped capture", cap_val, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule